// File: doc/BRIEF.md
# Burst Address Sequencer (Linear and Interleaved Orders)

This block produces the address for each beat of a short burst of up to four accesses. A start address is captured on a load. Each later advance then moves a beat counter forward. The two least significant address bits follow either a wrapping linear order or an XOR-based interleaved order. The upper address bits stay at the value captured on the load.

A memory controller uses it to issue up to four accesses from a single supplied address. It pulses `advance` high for each further beat and holds it low to start a new burst. A stall input freezes the sequencer completely. The order is sampled from `order_sel` at load time and stays fixed for the rest of that burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `addr_o` is all zeros until the first load or advance takes effect.
- R2: A clock edge with `stall` low and `advance` low captures a new burst. From the next cycle `addr_o` equals `{upper_addr, start_lo}` and the beat index is 0, whatever `order_sel` is.
- R3: A clock edge with `stall` low and `advance` high steps the beat index by one modulo 4. The inputs `start_lo` and `upper_addr` are ignored on such an edge, and the upper address bits stay unchanged.
- R4: With linear order latched (`order_sel` = 0 at load), the low two bits `addr_o[1:0]` at beat k equal (s + k) mod 4, where s is the captured start.
- R5: With interleaved order latched (`order_sel` = 1 at load), `addr_o[1:0]` at beat k equals s XOR k.
- R6: After the fourth beat (k = 3), a further advance wraps to beat 0, so `addr_o` returns to the captured start address.
- R7: A clock edge with `stall` high changes nothing: `addr_o` holds its value, whether `advance` is high or low.
- R8: `order_sel` is sampled only on a load. Changing it during a burst does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | High: the edge is ignored (no load, no advance) |
| advance | input | 1 | Low: load a new start address; high: step to the next beat |
| order_sel | input | 1 | Burst order sampled at load: 0 linear, 1 interleaved |
| start_lo | input | 2 | Two low bits of the start address |
| upper_addr | input | ADDR_W-2 | Upper address bits, captured on load |
| addr_o | output | ADDR_W | Full address of the current beat |

## Verification
The assertions assume that every input is a defined 0 or 1 at each rising edge and that reset is released away from an edge. They check only the step from one edge to the next, so no burst has to run to completion. The stimulus changes inputs only on falling edges and draws every bit from a seeded `$urandom`. This mixes loads, advances and stalls in any order, including advances that run well past four beats. Directed runs add both orders from every start value and a mode change in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int LO_W = 2;
  localparam int BEATS = 1 << LO_W;

  typedef logic [LO_W-1:0] lo_t;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  // Wrapping linear position: start plus beat, modulo the group size.
  function automatic lo_t linear_pos(input lo_t start, input lo_t beat);
    return lo_t'(start + beat);
  endfunction

  // Interleaved position: start with beat bits toggled.
  function automatic lo_t xor_pos(input lo_t start, input lo_t beat);
    return start ^ beat;
  endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic do_load,
  input  logic do_step,
  output lo_t  beat
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat <= '0;
    end else if (do_load) begin
      beat <= '0;
    end else if (do_step) begin
      beat <= lo_t'(beat + 1'b1);
    end
  end

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_step && !do_load |=> beat == lo_t'($past(beat) + 1'b1));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_step && !do_load && beat == lo_t'(BEATS - 1) |=> beat == '0);

  assert_load_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> beat == '0);

endmodule

// File: rtl/burst_order.sv
module burst_order
  import burst_seq_pkg::*;
(
  input  lo_t    start,
  input  lo_t    beat,
  input  order_e order,
  output lo_t    pos
);

  lo_t lin_pos;
  lo_t ilv_pos;

  always_comb begin
    lin_pos = linear_pos(start, beat);
    ilv_pos = xor_pos(start, beat);
    pos     = (order == ORD_XOR) ? ilv_pos : lin_pos;
  end

  // At beat 0 both orders give the start position back.
  always_comb begin
    if (beat == '0) begin
      assert_beat0_start_R2: assert (pos == start);
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  localparam int UP_W = ADDR_W - LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [LO_W-1:0]   start_lo,
  input  logic [UP_W-1:0]   upper_addr,
  output logic [ADDR_W-1:0] addr_o
);

  // Named events, used by the logic and by the assertions.
  logic do_load;
  logic do_step;
  assign do_load = !stall && !advance;
  assign do_step = !stall && advance;

  lo_t             start_q;
  logic [UP_W-1:0] upper_q;
  order_e          order_q;
  lo_t             beat;
  lo_t             pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      upper_q <= '0;
      order_q <= ORD_LINEAR;
    end else if (do_load) begin
      start_q <= start_lo;
      upper_q <= upper_addr;
      order_q <= order_e'(order_sel);
    end
  end

  burst_beat_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .do_load (do_load),
    .do_step (do_step),
    .beat    (beat)
  );

  burst_order u_ord (
    .start (start_q),
    .beat  (beat),
    .order (order_q),
    .pos   (pos)
  );

  assign addr_o = {upper_q, pos};

  assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> addr_o == {$past(upper_addr), $past(start_lo)});

  assert_upper_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_step |=> addr_o[ADDR_W-1:LO_W] == $past(addr_o[ADDR_W-1:LO_W]));

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_step && order_q == ORD_LINEAR |=> pos == lo_t'($past(pos) + 1'b1));

  assert_xor_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    do_step && order_q == ORD_XOR |=> (pos ^ $past(pos)) == (beat ^ $past(beat)));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(addr_o));

  assert_order_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !do_load |=> $stable(order_q));

  always_comb begin
    if (!rst_n) begin
      assert_reset_zero_R1: assert (addr_o == '0);
    end
  end

endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 19;
  localparam int UP_W = ADDR_W - 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              stall = 1'b0;
  logic              advance = 1'b0;
  logic              order_sel = 1'b0;
  logic [1:0]        start_lo = '0;
  logic [UP_W-1:0]   upper_addr = '0;
  logic [ADDR_W-1:0] addr_o;

  int checks = 0;
  int errors = 0;

  // Bench model state.
  logic [1:0]      m_start = '0;
  logic [1:0]      m_k = '0;
  logic            m_ilv = 1'b0;
  logic [UP_W-1:0] m_up = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall), .advance(advance),
    .order_sel(order_sel), .start_lo(start_lo), .upper_addr(upper_addr),
    .addr_o(addr_o)
  );

  // Expected low bits: linear adds modulo 4, interleaved flips bits.
  function automatic logic [1:0] exp_lo(input logic [1:0] s, input logic [1:0] k,
                                        input logic ilv);
    int sum;
    if (ilv) return {s[1] ^ k[1], s[0] ^ k[0]};
    sum = (int'(s) + int'(k)) % 4;
    return sum[1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr();
    return {m_up, exp_lo(m_start, m_k, m_ilv)};
  endfunction

  task automatic check(input string tag, input logic [ADDR_W-1:0] exp);
    checks++;
    if (addr_o !== exp) begin
      errors++;
      $display("FAIL %s: addr_o=%h expected=%h", tag, addr_o, exp);
    end
  endtask

  // Called at a falling edge: drive, pass one rising edge, update model, check.
  task automatic cyc(input logic st, input logic adv, input logic ord,
                     input logic [1:0] s, input logic [UP_W-1:0] up, input string tag);
    stall = st; advance = adv; order_sel = ord; start_lo = s; upper_addr = up;
    @(posedge clk);
    @(negedge clk);
    if (!st) begin
      if (!adv) begin
        m_start = s; m_k = 2'd0; m_ilv = ord; m_up = up;
      end else begin
        m_k = m_k + 2'd1;
      end
    end
    check(tag, exp_addr());
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    @(negedge clk);
    check("R1 during reset", '0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 after release", '0);
    cyc(1'b1, 1'b0, 1'b1, 2'd3, 17'h1abcd, "R1 stalled load keeps zero");

    // Every start in both orders, five advances each (wrap on the fourth).
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        cyc(1'b0, 1'b0, o[0], s[1:0], UP_W'(17'h0f00 + s), "R2 load");
        for (int b = 0; b < 5; b++)
          cyc(1'b0, 1'b1, ~o[0], ~s[1:0], '1, o == 0 ? "R4 linear beat" : "R5 interleaved beat");
      end
    end

    // Directed: start 1 interleaved gives 1,0,3,2 then back to 1.
    cyc(1'b0, 1'b0, 1'b1, 2'd1, 17'h00055, "R2 load start1");
    cyc(1'b0, 1'b1, 1'b1, 2'd0, '0, "R5 beat1");
    check("R5 beat1 value", {17'h00055, 2'd0});
    cyc(1'b0, 1'b1, 1'b0, 2'd0, '0, "R8 mode flip mid burst");
    check("R8 still interleaved", {17'h00055, 2'd3});
    cyc(1'b0, 1'b1, 1'b1, 2'd0, '0, "R5 beat3");
    cyc(1'b0, 1'b1, 1'b1, 2'd0, '0, "R6 wrap");
    check("R6 wrap value", {17'h00055, 2'd1});

    // Stall holds through advance and load attempts.
    cyc(1'b1, 1'b1, 1'b0, 2'd2, 17'h1ffff, "R7 stall advance");
    cyc(1'b1, 1'b0, 1'b0, 2'd2, 17'h1ffff, "R7 stall load");
    check("R7 held value", {17'h00055, 2'd1});

    // Upper address inputs ignored while advancing.
    cyc(1'b0, 1'b1, 1'b0, 2'd3, 17'h12345, "R3 upper ignored");

    // Random mix.
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[1:0] == 2'b00, r[4:2] != 3'b000, r[5], r[7:6], UP_W'(r[31:8]), "R3 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule